// File: doc/BRIEF.md
# Asynchronous SRAM Bus Cycle Controller

This block sits between a synchronous host and an asynchronous byte-wide static RAM (11 address bits, 8 data bits). It converts one read or write request at a time into a strobe sequence. The sequence respects the memory's access time, its write-pulse and data-setup minimums, its write recovery gap and its minimum cycle time. Every memory-side signal comes straight from a flip-flop, so the strobes cannot glitch.

All timing minimums are parameters in nanoseconds, together with the clock period. The controller rounds each one up to whole clock cycles at elaboration. A read drops chip enable and output enable together and samples the data-in bus at the edge that closes the access window. A write drops chip enable and write enable together with the data bus driven. It releases both strobes on the same edge and keeps driving data for one more cycle. After either operation a recovery phase keeps all strobes high. A single-cycle done pulse marks the return to idle, and a new request can be taken in that same cycle.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While rst_ni is low, mem_ce_n_o, mem_oe_n_o and mem_we_n_o are 1, and mem_dout_en_o and done_o are 0.
- R2: For a read (wr_i = 0), chip enable and output enable go low on the edge that accepts the request, with write enable high. They stay low for RD_CYC cycles, where RD_CYC is the largest of the rounded-up access, chip-enable and output-enable times (10 with defaults). rdata_o takes mem_din_i at the edge where they rise.
- R3: For a write (wr_i = 1), chip enable and write enable fall on the same edge and stay low for WP_CYC cycles. WP_CYC is the larger of the rounded-up write pulse and data setup times (8 with defaults). Both strobes rise on the same edge, and output enable is never low while write enable is low.
- R4: mem_addr_o is constant while chip enable is low, and mem_dout_o is constant while mem_dout_en_o is high.
- R5: mem_dout_en_o rises with write enable's fall and drops exactly one cycle after write enable rises. It is never high while output enable is low.
- R6: After the strobes rise, all strobes stay high for a recovery phase of at least two cycles. Its length is the largest of 2, the rounded-up recovery time, and the rounded-up cycle time minus the access phase (2 for both kinds with defaults). done_o is high for exactly one cycle, the first idle cycle, which falls RD_CYC+REC or WP_CYC+REC cycles after the accepting edge.
- R7: req_i is sampled only while idle, including the done cycle, and is accepted on the next edge. A request raised while busy is dropped, not queued, and starts no memory cycle.
- R8: rdata_o keeps its value until the next read completes. A write does not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request, sampled while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Last read data |
| done_o | output | 1 | One-cycle completion pulse |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_dout_o | output | DATA_W | Data toward memory |
| mem_dout_en_o | output | 1 | Data bus drive enable |
| mem_din_i | input | DATA_W | Data from memory |

## Verification
The completion pulse and the acceptance of the next request land on the same edge. The bench raises the next request in the very cycle it sees done_o. It then expects the new strobe fall one edge later, so operations run back to back with only the recovery gap between them. The write-to-read turnaround is exercised the same way. A write followed at once by a read of that address must show the drive enable already low before output enable falls, and must return the written byte. The memory model hands back a poisoned byte until the full access time has passed.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_RECOV = 2'd3
  } seq_state_e;

  function automatic int cyc_ceil(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int RD_CYC = 10,
  parameter int WP_CYC = 8,
  parameter int REC_RD = 2,
  parameter int REC_WR = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic             cnt_zero_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic             launch_rd_o,
  output logic             launch_wr_o,
  output logic             finish_rd_o,
  output logic             finish_wr_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] RRD_LD = CNT_W'(REC_RD - 1);
  localparam logic [CNT_W-1:0] RWR_LD = CNT_W'(REC_WR - 1);

  seq_state_e state_q, state_d;
  logic       done_q;
  logic       rec_end;

  assign launch_rd_o = (state_q == ST_IDLE) && req_i && !wr_i;
  assign launch_wr_o = (state_q == ST_IDLE) && req_i && wr_i;
  assign finish_rd_o = (state_q == ST_READ) && cnt_zero_i;
  assign finish_wr_o = (state_q == ST_WRITE) && cnt_zero_i;
  assign rec_end     = (state_q == ST_RECOV) && cnt_zero_i;

  assign cnt_load_o = launch_rd_o | launch_wr_o | finish_rd_o | finish_wr_o;

  always_comb begin
    cnt_val_o = '0;
    if (launch_rd_o)      cnt_val_o = RD_LD;
    else if (launch_wr_o) cnt_val_o = WP_LD;
    else if (finish_rd_o) cnt_val_o = RRD_LD;
    else if (finish_wr_o) cnt_val_o = RWR_LD;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_i) state_d = wr_i ? ST_WRITE : ST_READ;
      ST_READ:  if (cnt_zero_i) state_d = ST_RECOV;
      ST_WRITE: if (cnt_zero_i) state_d = ST_RECOV;
      ST_RECOV: if (cnt_zero_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= rec_end;
    end
  end

  assign done_o = done_q;

  // R6
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE));

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_rd_i,
  input  logic              launch_wr_i,
  input  logic              finish_rd_i,
  input  logic              finish_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_din_i,
  output logic              ce_n_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dout_o,
  output logic              mem_dout_en_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic              ce_n_q, oe_n_q, we_n_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] dout_q, rdata_q;
  logic              dout_en_q, hold_q;
  logic              launch, finish;

  assign launch = launch_rd_i | launch_wr_i;
  assign finish = finish_rd_i | finish_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_q    <= 1'b1;
      oe_n_q    <= 1'b1;
      we_n_q    <= 1'b1;
      addr_q    <= '0;
      dout_q    <= '0;
      dout_en_q <= 1'b0;
      hold_q    <= 1'b0;
      rdata_q   <= '0;
    end else begin
      hold_q <= finish_wr_i;
      if (launch) begin
        ce_n_q <= 1'b0;
        addr_q <= addr_i;
      end
      if (launch_rd_i) oe_n_q <= 1'b0;
      if (launch_wr_i) begin
        we_n_q    <= 1'b0;
        dout_q    <= wdata_i;
        dout_en_q <= 1'b1;
      end else if (hold_q) begin
        dout_en_q <= 1'b0;
      end
      // both strobes rise together: write window closes on one edge
      if (finish) begin
        ce_n_q <= 1'b1;
        oe_n_q <= 1'b1;
        we_n_q <= 1'b1;
      end
      if (finish_rd_i) rdata_q <= mem_din_i;
    end
  end

  assign ce_n_o        = ce_n_q;
  assign oe_n_o        = oe_n_q;
  assign we_n_o        = we_n_q;
  assign mem_addr_o    = addr_q;
  assign mem_dout_o    = dout_q;
  assign mem_dout_en_o = dout_en_q;
  assign rdata_o       = rdata_q;

  // R3
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_n_q && !we_n_q));

  // R3
  we_ce_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_q) |-> $rose(ce_n_q));

  // R5
  drive_vs_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_q |-> oe_n_q);

  // R5
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_q) |-> dout_en_q ##1 !dout_en_q);

  // R4
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_q && $past(!ce_n_q)) |-> $stable(addr_q));

  // R4
  data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_en_q && $past(dout_en_q)) |-> $stable(dout_q));

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_ACC_NS  = 100,
  parameter int T_CO_NS   = 100,
  parameter int T_OE_NS   = 50,
  parameter int T_WP_NS   = 75,
  parameter int T_DS_NS   = 40,
  parameter int T_WR_NS   = 10,
  parameter int T_CYC_NS  = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              mem_ce_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dout_o,
  output logic              mem_dout_en_o,
  input  logic [DATA_W-1:0] mem_din_i
);

  localparam int RD_CYC  = max2(max2(cyc_ceil(T_ACC_NS, CLK_NS), cyc_ceil(T_CO_NS, CLK_NS)),
                                max2(cyc_ceil(T_OE_NS, CLK_NS), 1));
  localparam int WP_CYC  = max2(max2(cyc_ceil(T_WP_NS, CLK_NS), cyc_ceil(T_DS_NS, CLK_NS)), 1);
  localparam int CYC_CYC = cyc_ceil(T_CYC_NS, CLK_NS);
  localparam int REC_BASE = max2(2, cyc_ceil(T_WR_NS, CLK_NS));
  localparam int REC_RD  = max2(REC_BASE, CYC_CYC - RD_CYC);
  localparam int REC_WR  = max2(REC_BASE, CYC_CYC - WP_CYC);
  localparam int REC_MIN = (REC_RD < REC_WR) ? REC_RD : REC_WR;
  localparam int MAX_CYC = max2(max2(RD_CYC, WP_CYC), max2(REC_RD, REC_WR));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int LEN_W   = CNT_W + 1;

  logic             cnt_load, cnt_zero;
  logic [CNT_W-1:0] cnt_val;
  logic             launch_rd, launch_wr, finish_rd, finish_wr;

  sram_wait_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .zero_o     (cnt_zero)
  );

  sram_seq_fsm #(
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .REC_RD (REC_RD),
    .REC_WR (REC_WR)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .wr_i        (wr_i),
    .cnt_zero_i  (cnt_zero),
    .cnt_load_o  (cnt_load),
    .cnt_val_o   (cnt_val),
    .launch_rd_o (launch_rd),
    .launch_wr_o (launch_wr),
    .finish_rd_o (finish_rd),
    .finish_wr_o (finish_wr),
    .done_o      (done_o)
  );

  sram_pin_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .launch_rd_i   (launch_rd),
    .launch_wr_i   (launch_wr),
    .finish_rd_i   (finish_rd),
    .finish_wr_i   (finish_wr),
    .addr_i        (addr_i),
    .wdata_i       (wdata_i),
    .mem_din_i     (mem_din_i),
    .ce_n_o        (mem_ce_n_o),
    .oe_n_o        (mem_oe_n_o),
    .we_n_o        (mem_we_n_o),
    .mem_addr_o    (mem_addr_o),
    .mem_dout_o    (mem_dout_o),
    .mem_dout_en_o (mem_dout_en_o),
    .rdata_o       (rdata_o)
  );

  // independent strobe width and gap monitors
  localparam logic [LEN_W-1:0] RD_LEN  = LEN_W'(RD_CYC);
  localparam logic [LEN_W-1:0] WP_LEN  = LEN_W'(WP_CYC);
  localparam logic [LEN_W-1:0] REC_LEN = LEN_W'(REC_MIN);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [LEN_W-1:0] we_low_len, oe_low_len, ce_gap_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_low_len <= '0;
      oe_low_len <= '0;
      ce_gap_len <= LEN_MAX;
    end else begin
      we_low_len <= mem_we_n_o ? '0 : we_low_len + 1'b1;
      oe_low_len <= mem_oe_n_o ? '0 : oe_low_len + 1'b1;
      if (!mem_ce_n_o)              ce_gap_len <= '0;
      else if (ce_gap_len != LEN_MAX) ce_gap_len <= ce_gap_len + 1'b1;
    end
  end

  // R2
  rd_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_n_o) |-> (oe_low_len == RD_LEN));

  // R3
  wr_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (we_low_len == WP_LEN));

  // R6
  rec_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_ce_n_o) |-> (ce_gap_len >= REC_LEN));

endmodule

// File: tb/sim_sram_cycle_ctrl.sv
module sim_sram_cycle_ctrl;

  localparam int AW = 11;
  localparam int DW = 8;
  localparam int NWORDS = 1 << AW;

  function automatic int up(input int t);
    return (t + 9) / 10;
  endfunction

  localparam int RD_E  = (up(100) > up(50)) ? up(100) : up(50);
  localparam int WP_E  = (up(75) > up(40)) ? up(75) : up(40);
  localparam int REC_E = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          done;
  logic          ce_n, oe_n, we_n, dout_en;
  logic [AW-1:0] maddr;
  logic [DW-1:0] dout, din;

  always #5 clk = ~clk;

  sram_cycle_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .mem_ce_n_o(ce_n),
    .mem_oe_n_o(oe_n), .mem_we_n_o(we_n), .mem_addr_o(maddr),
    .mem_dout_o(dout), .mem_dout_en_o(dout_en), .mem_din_i(din)
  );

  // memory model: byte is poisoned until the access window has elapsed
  logic [DW-1:0] mem [NWORDS];
  int            rd_cnt = 0;
  always @(posedge clk) begin
    rd_cnt <= (!ce_n && !oe_n) ? rd_cnt + 1 : 0;
    if (!ce_n && !we_n) mem[maddr] <= dout;
  end
  assign din = (!ce_n && !oe_n && we_n && rd_cnt >= RD_E - 1) ? mem[maddr] : 8'hEE;

  int n_cmp = 0, n_bad = 0, ops = 0, ce_falls = 0;
  bit finished = 0, mon_en = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pat1(input int a);
    return (a * 37 + a / 8) & 255;
  endfunction
  function automatic int pat2(input int a);
    return (~pat1(a) ^ (a >> 3)) & 255;
  endfunction

  // protocol monitor, sampled mid-cycle
  logic          p_we = 1, p_oe = 1, p_ce = 1, p_den = 0, p_done = 0;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dout = '0;
  int            we_len = 0, oe_len = 0, we_hi = 0, ce_hi = 100;
  always @(negedge clk) if (mon_en) begin
    if (!ce_n && !p_ce) chk(maddr == p_addr, "R4 addr", maddr, p_addr);
    if (dout_en && p_den) chk(dout == p_dout, "R4 data", dout, p_dout);
    if (!we_n) chk(oe_n == 1'b1, "R3 oe during write", oe_n, 1);
    if (dout_en) chk(oe_n == 1'b1, "R5 drive vs oe", oe_n, 1);
    if (we_n && !p_we) begin
      chk(we_len == WP_E, "R3 we width", we_len, WP_E);
      chk(ce_n == 1'b1, "R3 ce rise", ce_n, 1);
      chk(dout_en == 1'b1, "R5 hold", dout_en, 1);
    end
    if (!dout_en && p_den) chk(we_hi == 1, "R5 release", we_hi + 1, 2);
    if (oe_n && !p_oe) chk(oe_len == RD_E, "R2 oe width", oe_len, RD_E);
    if (!ce_n && p_ce) begin
      ce_falls++;
      chk(ce_hi >= REC_E, "R6 recovery gap", ce_hi, REC_E);
    end
    if (done && p_done) chk(0, "R6 done width", 2, 1);
    we_len = we_n ? 0 : we_len + 1;
    oe_len = oe_n ? 0 : oe_len + 1;
    we_hi  = we_n ? we_hi + 1 : 0;
    ce_hi  = ce_n ? ce_hi + 1 : 0;
    p_we = we_n; p_oe = oe_n; p_ce = ce_n; p_den = dout_en; p_done = done;
    p_addr = maddr; p_dout = dout;
  end

  // starts and returns at a negedge; intrude_at >= 0 pulses a stray write request
  task automatic run_op(input bit w, input int a, input int d, input int exp_rd,
                        input int intrude_at);
    int n = 0, m = 0;
    req = 1'b1; wr = w; addr = AW'(a); wdata = DW'(d);
    ops++;
    do begin @(negedge clk); n++; end while (ce_n && n < 50);
    chk(n == 1, "R7 accept latency", n, 1);
    chk(oe_n == w && we_n == !w, "R7 op select", {oe_n, we_n}, w ? 2 : 1);
    req = 1'b0;
    while (!done && m < 100) begin
      @(negedge clk); m++;
      if (m == intrude_at) begin req = 1'b1; wr = 1'b1; wdata = ~DW'(d); end
      if (m == intrude_at + 1) req = 1'b0;
    end
    chk(m == (w ? WP_E : RD_E) + REC_E, "R6 done timing", m, (w ? WP_E : RD_E) + REC_E);
    if (!w) chk(rdata == exp_rd, "R2 read data", rdata, exp_rd);
  endtask

  initial begin
    for (int i = 0; i < NWORDS; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && we_n, "R1 strobes", {ce_n, oe_n, we_n}, 7);
    chk(!dout_en && !done, "R1 drive/done", {dout_en, done}, 0);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    @(negedge clk);
    // pass 1: fill ascending, back to back
    for (int a = 0; a < NWORDS; a++) run_op(1'b1, a, pat1(a), 0, -1);
    // pass 2: read ascending; stray requests while busy must be dropped
    for (int a = 0; a < NWORDS; a++) run_op(1'b0, a, 0, pat1(a), (a % 256 == 5) ? 3 : -1);
    // R7: stray writes carried ~data; contents must be untouched
    for (int a = 5; a < NWORDS; a += 256) run_op(1'b0, a, 0, pat1(a), -1);
    // pass 3: descending write then immediate read of the same byte (turnaround)
    for (int a = NWORDS - 1; a >= 0; a--) begin
      run_op(1'b1, a, pat2(a), 0, -1);
      run_op(1'b0, a, 0, pat2(a), -1);
    end
    // R8: write leaves last read data intact
    run_op(1'b0, 100, 0, pat2(100), -1);
    run_op(1'b1, 200, 8'h5A, 0, -1);
    chk(rdata == pat2(100), "R8 rdata after write", rdata, pat2(100));
    repeat (4) @(negedge clk);
    chk(ce_falls == ops, "R7 no extra cycles", ce_falls, ops);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule